// File: doc/BRIEF.md
# Gated Full-Duplex TDM Channel Port

This block exchanges one 8-bit word per frame with a time-division serial bus. It sends and receives in the same slot. The slot is not found by counting bits from a frame marker. It is simply the time during which two active-low strobes, a slot select and a frame gate, are both low. The bit clock is nominally 2.048 MHz.

On the transmit side, the parallel word present when the slot opens is captured and sent most significant bit first. The serial output is three-state and is driven only inside the slot. On the receive side, the serial input is sampled on the falling clock edge during the slot. Once eight bits have arrived, the assembled word appears on a parallel output together with a one-cycle valid strobe. A slot that closes early leaves no trace on the receive side.

Top module: `tdm_chan_port`

## Requirements
- R1: `ser_oe` is 1 only in cycles where both `slot_n` and `frame_n` are 0. While it is 0, `ser_out` is high impedance. Any cycle with either strobe high restarts both directions at bit 0.
- R2: In the first cycle of a slot, `ser_oe` is 1 and `ser_out` equals bit 7 of `tx_word` as presented in that same cycle.
- R3: In cycle j (0..7) of the slot, `ser_out` carries bit 7-j of the word captured in cycle 0. Changes to `tx_word` after cycle 0 have no effect on the bits sent in that slot.
- R4: After eight bits have been sent, `ser_oe` returns to 0 even if both strobes stay low.
- R5: During the slot, `ser_in` is sampled on the falling clock edge. The first bit sampled ends up in bit 7 of `rx_word`.
- R6: In the cycle after the eighth bit is sampled, `rx_word` holds the new word and `rx_valid` is 1 for exactly one cycle.
- R7: If a slot closes after fewer than eight bits, `rx_valid` stays 0 and `rx_word` keeps its previous value.
- R8: During and right after reset, `ser_oe` = 0, `rx_valid` = 0 and `rx_word` = 0.
- R9: Input bits sampled after the eighth bit of a long slot are ignored. They change neither `rx_word` nor `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_n | input | 1 | Active-low channel select strobe |
| frame_n | input | 1 | Active-low frame gate strobe |
| tx_word | input | 8 | Word to transmit in the next slot |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Three-state serial transmit data |
| ser_oe | output | 1 | High when `ser_out` is driven |
| rx_word | output | 8 | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is refreshed |

## Verification
The transmit outputs respond to the strobes in the same cycle through combinational paths. Each later bit appears one rising edge after the one before it. A received bit is captured on the falling edge inside its cycle, and the completed word and its valid strobe appear one rising edge after the eighth sample. The bench changes the inputs 1 ns after each rising edge, which is before the falling edge. It compares every output 4 ns after the edge against a behavioural model. That model advances once per cycle, so each result is checked in exactly the cycle in which it falls due.

// File: rtl/tdm_chan_pkg.sv
`timescale 1ns/1ps
package tdm_chan_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/tdm_slot_gate.sv
`timescale 1ns/1ps
module tdm_slot_gate (
    input  logic slot_n,
    input  logic frame_n,
    output logic win
);
    // The slot is open while both active-low strobes are asserted.
    assign win = ~slot_n & ~frame_n;
endmodule

// File: rtl/tdm_tx_shift.sv
`timescale 1ns/1ps
module tdm_tx_shift
    import tdm_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  win,
    input  word_t tx_word,
    output logic  bit_out,
    output logic  drive
);
    localparam cnt_t LAST = cnt_t'(WORD_W);

    typedef struct packed {
        word_t shift;
        cnt_t  cnt;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic first;

    always_comb begin
        first   = (st_q.cnt == '0);
        bit_out = first ? tx_word[WORD_W-1] : st_q.shift[WORD_W-1];
        drive   = win && (st_q.cnt < LAST);
        st_d    = st_q;
        if (!win) begin
            st_d.cnt = '0;
        end else if (first) begin
            // Snapshot at slot opening; bit 7 already on the line this cycle.
            st_d.shift = tx_word << 1;
            st_d.cnt   = cnt_t'(1);
        end else if (st_q.cnt < LAST) begin
            st_d.shift = st_q.shift << 1;
            st_d.cnt   = st_q.cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_gap_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !win |=> (st_q.cnt == '0));

    assert_bit_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    assert_contiguous_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !first) |-> $past(drive));
endmodule

// File: rtl/tdm_rx_shift.sv
`timescale 1ns/1ps
module tdm_rx_shift
    import tdm_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  win,
    input  logic  ser_in,
    output word_t word_out,
    output logic  valid_out
);
    localparam cnt_t LAST = cnt_t'(WORD_W);

    typedef struct packed {
        logic bit_v;
        logic inwin;
    } smp_t;

    typedef struct packed {
        word_t shift;
        cnt_t  cnt;
        word_t word;
        logic  valid;
    } rx_state_t;

    smp_t      smp_d, smp_q;
    rx_state_t st_d, st_q;

    // Falling-edge sampler: records the data bit and whether the slot was open.
    always_comb begin
        smp_d.bit_v = ser_in;
        smp_d.inwin = win;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!smp_q.inwin) begin
            st_d.cnt = '0;           // partial word dropped
        end else if (st_q.cnt < LAST) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], smp_q.bit_v};
            st_d.cnt   = st_q.cnt + cnt_t'(1);
            if (st_q.cnt == LAST - cnt_t'(1)) begin
                st_d.word  = {st_q.shift[WORD_W-2:0], smp_q.bit_v};
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_out  = st_q.word;
    assign valid_out = st_q.valid;

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    assert_pulse_needs_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(smp_q.inwin));

    assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.word));
endmodule

// File: rtl/tdm_chan_port.sv
`timescale 1ns/1ps
module tdm_chan_port
    import tdm_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_n,
    input  logic       frame_n,
    input  logic [7:0] tx_word,
    input  logic       ser_in,
    output logic       ser_out,
    output logic       ser_oe,
    output logic [7:0] rx_word,
    output logic       rx_valid
);
    logic  win;
    logic  tx_bit;
    logic  tx_drive;
    word_t rx_w;

    tdm_slot_gate u_gate (
        .slot_n  (slot_n),
        .frame_n (frame_n),
        .win     (win)
    );

    tdm_tx_shift u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .win     (win),
        .tx_word (word_t'(tx_word)),
        .bit_out (tx_bit),
        .drive   (tx_drive)
    );

    tdm_rx_shift u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .ser_in    (ser_in),
        .word_out  (rx_w),
        .valid_out (rx_valid)
    );

    assign ser_oe  = tx_drive;
    assign ser_out = tx_drive ? tx_bit : 1'bz;
    assign rx_word = 8'(rx_w);

    assert_oe_in_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (!slot_n && !frame_n));
endmodule

// File: tb/tdm_chan_port_tb.sv
`timescale 1ns/1ps
module tdm_chan_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_n = 1'b1;
    logic       frame_n = 1'b1;
    logic [7:0] tx_word = 8'h00;
    logic       ser_in = 1'b0;
    logic       ser_out, ser_oe, rx_valid;
    logic [7:0] rx_word;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state
    int         m_txn = 0;
    int         m_rxn = 0;
    logic [7:0] m_snap = 8'h00;
    logic [7:0] m_bits = 8'h00;
    logic [7:0] m_rxw = 8'h00;
    bit         m_pend = 0;
    logic [7:0] lfsr = 8'h5b;

    always #2.5 clk = ~clk;

    tdm_chan_port u_dut (
        .clk(clk), .rst_n(rst_n), .slot_n(slot_n), .frame_n(frame_n),
        .tx_word(tx_word), .ser_in(ser_in), .ser_out(ser_out),
        .ser_oe(ser_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic a_n, input logic f_n, input logic [7:0] tw, input logic b);
        bit win, e_oe, nxt;
        @(posedge clk);
        #1;
        slot_n = a_n; frame_n = f_n; tx_word = tw; ser_in = b;
        #3;
        win  = !a_n && !f_n;
        e_oe = win && (m_txn < 8);
        cmp("R1/R4 ser_oe", {7'd0, ser_oe}, {7'd0, e_oe});
        if (e_oe)
            cmp("R2/R3 ser_out", {7'd0, ser_out},
                {7'd0, (m_txn == 0) ? tw[7] : m_snap[7 - m_txn]});
        cmp("R6/R7/R9 rx_valid", {7'd0, rx_valid}, {7'd0, m_pend});
        cmp("R5/R7/R9 rx_word", rx_word, m_rxw);
        nxt = 0;
        if (win) begin
            if (m_txn == 0) m_snap = tw;
            if (m_txn < 8) m_txn++;
            if (m_rxn < 8) begin
                m_bits = {m_bits[6:0], b};
                m_rxn++;
                if (m_rxn == 8) begin m_rxw = m_bits; nxt = 1; end
            end
        end else begin
            m_txn = 0; m_rxn = 0;
        end
        m_pend = nxt;
    endtask

    // Slot of given length; rx bits come from rxw MSB first, then lfsr noise.
    task automatic slot(input int len, input logic [7:0] tw, input logic [7:0] rxw, input bit chg);
        for (int i = 0; i < len; i++) begin
            logic b;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            b = (i < 8) ? rxw[7 - i] : lfsr[0];
            step(1'b0, 1'b0, (chg && i > 0) ? ~tw : tw, b);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 8'hff, 1'b1);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #4;
        cmp("R8 ser_oe", {7'd0, ser_oe}, 8'd0);
        cmp("R8 rx_valid", {7'd0, rx_valid}, 8'd0);
        cmp("R8 rx_word", rx_word, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2/R3/R5/R6: exact 8-bit slot
        slot(8, 8'h3c, 8'ha5, 0);
        idle(3);
        // R1: only one strobe low
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'h81, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h81, 1'b0);
        // R3: tx_word changes during slot
        slot(8, 8'hc9, 8'h5a, 1);
        idle(2);
        // R4/R9: long slot
        slot(13, 8'h96, 8'h0f, 0);
        idle(2);
        // R7: short slot, then fresh full slot
        slot(5, 8'hf0, 8'hff, 0);
        idle(1);
        slot(8, 8'h01, 8'h80, 0);
        idle(1);
        // back-to-back with one-cycle gap, varied patterns
        for (int k = 0; k < 20; k++) begin
            slot(8 + (k % 3), 8'(k * 37 + 11), 8'(k * 91 + 3), k[0]);
            idle(1 + (k % 2));
        end
        slot(3, 8'h44, 8'h22, 0);
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule